// File: doc/BRIEF.md
# Processor Power Zone Sequencer

This block steps one processor power zone between its fully-off and fully-on states in a fixed order. On a power-up request it starts the PLL regulator, waits a settling time set by a parameter, and enables the PLL. It then turns on the logic power switches and waits for their status, asserts the logic power-good enables and waits again, and opens the PLL clamp and then the logic isolation clamp. Next it brings up the zone's memory: it clears the zone's power-down bit, enables memory power and waits, asserts memory power-good and waits, and opens the memory clamp. Releasing the core reset is always the last step.

A power-down request runs the same steps in the opposite order. The core reset is asserted first and the PLL regulator is turned off last, with the same settling time between PLL off and regulator off. Every step that waits on status has a timeout. On a timeout the block raises an error flag, goes back to idle and holds its outputs where they are. A parameter selects a secondary-core variant. That variant drives only the two lowest switch lanes and has no PLL steps.

Top module: `pwr_zone_seq`

## Requirements
- R1: Out of reset the zone is off: pll_ldo_en=0, pll_en=0, pll_clamp=1, sw_on_en=0, sw_ok_en=0, logic_clamp=1, mem_pd=4'hF, mem_on_en=0, mem_ok_en=0, mem_clamp=1, core_rst_n=0, busy=0, done=0, err=0.
- R2: Power-up enables pll_ldo_en and, no earlier than CLK_MHZ*SETTLE_US cycles later, pll_en. It then sets sw_on_en to the lane mask and waits until all masked sw_on_sts bits are 1. It then sets sw_ok_en to the mask and waits until all masked sw_ok_sts bits are 1. Only then are pll_clamp and, after it, logic_clamp driven to 0.
- R3: After the logic clamp opens, mem_pd bit 0 (the zone's own memory power-down bit) is cleared while bits above it stay 1. Then mem_on_en goes to 1 and the block waits for mem_on_sts=1. Then mem_ok_en goes to 1 and the block waits for mem_ok_sts=1. Then mem_clamp goes to 0. mem_on_en is never 1 while mem_pd bit 0 is 1.
- R4: core_rst_n goes to 1 only as the last power-up step, in the same cycle as the one-cycle done pulse, with mem_clamp and logic_clamp already 0.
- R5: Power-down drives core_rst_n to 0, then in order sets mem_clamp=1, clears mem_ok_en (waits mem_ok_sts=0), clears mem_on_en (waits mem_on_sts=0), sets mem_pd bit 0, sets logic_clamp=1 and pll_clamp=1, clears the masked sw_ok_en bits (waits for their status to be 0), and clears the masked sw_on_en bits (waits the same way). It then drops pll_en and, no earlier than CLK_MHZ*SETTLE_US cycles later, pll_ldo_en.
- R6: A power-up request while core_rst_n is 1, or a power-down request while the zone is fully off, gives a done pulse in the next cycle and changes no other output.
- R7: If any status wait lasts TMO_CYC cycles, err goes to 1 and the block returns to idle with every control output held. err is cleared when the next request is accepted.
- R8: Requests are sampled only while idle and are ignored while busy. If both requests are present at once, power-up wins.
- R9: With SECONDARY=1 only sw_on_en/sw_ok_en lanes 1:0 (mask 4'h3) are driven and waited on, and pll_ldo_en=0, pll_en=0, pll_clamp=1 are held.
- R10: busy is 1 from the cycle after a request that starts a sequence until the cycle the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Power-up request (sampled when idle) |
| dn_req | input | 1 | Power-down request (sampled when idle) |
| sw_on_sts | input | LANES | Logic power-switch on status |
| sw_ok_sts | input | LANES | Logic power-good status |
| mem_on_sts | input | 1 | Memory power-on status |
| mem_ok_sts | input | 1 | Memory power-good status |
| pll_ldo_en | output | 1 | PLL regulator enable |
| pll_en | output | 1 | PLL enable |
| pll_clamp | output | 1 | PLL isolation clamp (1 = clamped) |
| sw_on_en | output | LANES | Logic power-switch enables |
| sw_ok_en | output | LANES | Logic power-good enables |
| logic_clamp | output | 1 | Logic isolation clamp (1 = clamped) |
| mem_pd | output | MPD_W | Memory power-down field, bit 0 owned by this zone |
| mem_on_en | output | 1 | Memory power-on enable |
| mem_ok_en | output | 1 | Memory power-good enable |
| mem_clamp | output | 1 | Memory clamp (1 = clamped) |
| core_rst_n | output | 1 | Active-low core reset |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Status wait timed out |

## Verification
The main function is tried with a series of alternating power-up and power-down requests. The series includes repeated requests for the state the zone is already in, which separates the immediate-completion path from a real sequence. Two injected faults are used: a memory-on status stuck low during power-up, and a power-good status stuck high during power-down. Each stops the block at a different wait step, so the held output pattern shows exactly where the sequence stopped. A recovery sequence from each partial state then shows that the block resumes correctly. A monitor records when the PLL and regulator edges occur and what the clamps show at the reset release and at the logic clamp opening, so the ordering is checked as well as the end state. A second instance built as the secondary-core variant shows the lane mask and the missing PLL steps.

// File: rtl/pzs_pkg.sv
package pzs_pkg;
   typedef enum logic [4:0] {
      ST_IDLE,
      U_LDO, U_PLL, U_SWON, U_SWOK, U_PCL, U_LCL, U_MPD, U_MON, U_MOK, U_MCL,
      D_RST, D_MCL, D_MOK, D_MON, D_MPD, D_LCL, D_PCL, D_SWOK, D_SWON, D_PLL
   } pzs_state_e;

   function automatic logic is_status_wait(input pzs_state_e s);
      return (s == U_SWON) || (s == U_SWOK) || (s == U_MON) || (s == U_MOK) ||
             (s == D_MOK)  || (s == D_MON)  || (s == D_SWOK) || (s == D_SWON);
   endfunction
endpackage

// File: rtl/pzs_timer.sv
module pzs_timer #(
   parameter int CW   = 8,
   parameter int MAXV = 255
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] TOP = CW'(MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pzs_lane_check.sv
module pzs_lane_check #(
   parameter int               LANES = 4,
   parameter logic [LANES-1:0] MASK  = '1
) (
   input  logic [LANES-1:0] sts,
   output logic             all_set,
   output logic             all_clr
);
   logic [LANES-1:0] set_ok, clr_ok;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (MASK[i]) begin : g_used
         assign set_ok[i] = sts[i];
         assign clr_ok[i] = ~sts[i];
      end else begin : g_free
         assign set_ok[i] = 1'b1;
         assign clr_ok[i] = 1'b1;
      end
   end

   assign all_set = &set_ok;
   assign all_clr = &clr_ok;
endmodule

// File: rtl/pwr_zone_seq.sv
module pwr_zone_seq
   import pzs_pkg::*;
#(
   parameter int CLK_MHZ   = 100,
   parameter int SETTLE_US = 1,
   parameter int TMO_CYC   = 64,
   parameter int LANES     = 4,
   parameter int MPD_W     = 4,
   parameter bit SECONDARY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_req,
   input  logic             dn_req,
   input  logic [LANES-1:0] sw_on_sts,
   input  logic [LANES-1:0] sw_ok_sts,
   input  logic             mem_on_sts,
   input  logic             mem_ok_sts,
   output logic             pll_ldo_en,
   output logic             pll_en,
   output logic             pll_clamp,
   output logic [LANES-1:0] sw_on_en,
   output logic [LANES-1:0] sw_ok_en,
   output logic             logic_clamp,
   output logic [MPD_W-1:0] mem_pd,
   output logic             mem_on_en,
   output logic             mem_ok_en,
   output logic             mem_clamp,
   output logic             core_rst_n,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int DLY_CYC = CLK_MHZ * SETTLE_US;
   localparam int CNT_MAX = (DLY_CYC > TMO_CYC) ? DLY_CYC : TMO_CYC;
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam logic [CW-1:0]    DLY_LAST = CW'(DLY_CYC - 1);
   localparam logic [CW-1:0]    TMO_LAST = CW'(TMO_CYC - 1);
   localparam logic [LANES-1:0] LMASK    = SECONDARY ? {{(LANES-2){1'b0}}, 2'b11}
                                                     : {LANES{1'b1}};

   if (LANES < 3)   begin : g_bad_lanes $error("LANES must be 3 or more");   end
   if (MPD_W < 2)   begin : g_bad_mpd   $error("MPD_W must be 2 or more");   end
   if (DLY_CYC < 1) begin : g_bad_dly   $error("settle time must be >= 1"); end
   if (TMO_CYC < 2) begin : g_bad_tmo   $error("TMO_CYC must be >= 2");      end

   pzs_state_e       st;
   logic             ldo_q, pll_q, pclamp_q, lclamp_q, mpd0_q;
   logic             mon_q, mok_q, mclamp_q, crst_q, done_q, err_q, off_q;
   logic [LANES-1:0] swon_q, swok_q;
   logic [CW-1:0]    cnt;
   logic             on_all, on_none, ok_all, ok_none;
   logic             adv, tmo, dly_done;

   pzs_lane_check #(.LANES(LANES), .MASK(LMASK)) u_on_chk (
      .sts(sw_on_sts), .all_set(on_all), .all_clr(on_none));
   pzs_lane_check #(.LANES(LANES), .MASK(LMASK)) u_ok_chk (
      .sts(sw_ok_sts), .all_set(ok_all), .all_clr(ok_none));

   assign dly_done = (cnt >= DLY_LAST);

   always_comb begin
      unique case (st)
         ST_IDLE:       adv = 1'b0;
         U_LDO, D_PLL:  adv = dly_done;
         U_SWON:        adv = on_all;
         U_SWOK:        adv = ok_all;
         U_MON:         adv = mem_on_sts;
         U_MOK:         adv = mem_ok_sts;
         D_MOK:         adv = ~mem_ok_sts;
         D_MON:         adv = ~mem_on_sts;
         D_SWOK:        adv = ok_none;
         D_SWON:        adv = on_none;
         default:       adv = 1'b1;
      endcase
      tmo = is_status_wait(st) && !adv && (cnt >= TMO_LAST);
   end

   pzs_timer #(.CW(CW), .MAXV(CNT_MAX)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(adv || tmo || (st == ST_IDLE)), .cnt(cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         ldo_q <= 1'b0; pll_q <= 1'b0; pclamp_q <= 1'b1; lclamp_q <= 1'b1;
         swon_q <= '0;  swok_q <= '0;  mpd0_q <= 1'b1;
         mon_q <= 1'b0; mok_q <= 1'b0; mclamp_q <= 1'b1; crst_q <= 1'b0;
         done_q <= 1'b0; err_q <= 1'b0; off_q <= 1'b1;
      end else begin
         done_q <= 1'b0;
         if (tmo) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
         end else begin
            unique case (st)
               ST_IDLE: begin
                  if (up_req) begin
                     err_q <= 1'b0;
                     if (crst_q) done_q <= 1'b1;
                     else begin
                        off_q <= 1'b0;
                        if (SECONDARY) begin swon_q <= LMASK; st <= U_SWON; end
                        else begin ldo_q <= 1'b1; st <= U_LDO; end
                     end
                  end else if (dn_req) begin
                     err_q <= 1'b0;
                     if (off_q) done_q <= 1'b1;
                     else begin crst_q <= 1'b0; st <= D_RST; end
                  end
               end
               U_LDO:  if (adv) begin pll_q <= 1'b1; st <= U_PLL; end
               U_PLL:  begin swon_q <= swon_q | LMASK; st <= U_SWON; end
               U_SWON: if (adv) begin swok_q <= swok_q | LMASK; st <= U_SWOK; end
               U_SWOK: if (adv) begin pclamp_q <= 1'b0; st <= U_PCL; end
               U_PCL:  begin lclamp_q <= 1'b0; st <= U_LCL; end
               U_LCL:  begin mpd0_q <= 1'b0; st <= U_MPD; end
               U_MPD:  begin mon_q <= 1'b1; st <= U_MON; end
               U_MON:  if (adv) begin mok_q <= 1'b1; st <= U_MOK; end
               U_MOK:  if (adv) begin mclamp_q <= 1'b0; st <= U_MCL; end
               U_MCL:  begin crst_q <= 1'b1; done_q <= 1'b1; st <= ST_IDLE; end
               D_RST:  begin mclamp_q <= 1'b1; st <= D_MCL; end
               D_MCL:  begin mok_q <= 1'b0; st <= D_MOK; end
               D_MOK:  if (adv) begin mon_q <= 1'b0; st <= D_MON; end
               D_MON:  if (adv) begin mpd0_q <= 1'b1; st <= D_MPD; end
               D_MPD:  begin lclamp_q <= 1'b1; st <= D_LCL; end
               D_LCL:  begin pclamp_q <= 1'b1; st <= D_PCL; end
               D_PCL:  begin swok_q <= swok_q & ~LMASK; st <= D_SWOK; end
               D_SWOK: if (adv) begin swon_q <= swon_q & ~LMASK; st <= D_SWON; end
               D_SWON: if (adv) begin
                  if (SECONDARY) begin
                     done_q <= 1'b1; off_q <= 1'b1; st <= ST_IDLE;
                  end else begin
                     pll_q <= 1'b0; st <= D_PLL;
                  end
               end
               D_PLL:  if (adv) begin
                  ldo_q <= 1'b0; done_q <= 1'b1; off_q <= 1'b1; st <= ST_IDLE;
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   if (SECONDARY) begin : g_sec
      assign pll_ldo_en = 1'b0;
      assign pll_en     = 1'b0;
      assign pll_clamp  = 1'b1;
   end else begin : g_pri
      assign pll_ldo_en = ldo_q;
      assign pll_en     = pll_q;
      assign pll_clamp  = pclamp_q;
   end

   assign sw_on_en    = swon_q;
   assign sw_ok_en    = swok_q;
   assign logic_clamp = lclamp_q;
   assign mem_pd      = {{(MPD_W-1){1'b1}}, mpd0_q};
   assign mem_on_en   = mon_q;
   assign mem_ok_en   = mok_q;
   assign mem_clamp   = mclamp_q;
   assign core_rst_n  = crst_q;
   assign busy        = (st != ST_IDLE);
   assign done        = done_q;
   assign err         = err_q;
endmodule

// File: rtl/pzs_chk.sv
module pzs_chk #(
   parameter int LANES = 4,
   parameter int MPD_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pll_ldo_en,
   input logic             pll_en,
   input logic [LANES-1:0] sw_on_en,
   input logic [LANES-1:0] sw_ok_en,
   input logic             logic_clamp,
   input logic [MPD_W-1:0] mem_pd,
   input logic             mem_on_en,
   input logic             mem_clamp,
   input logic             core_rst_n,
   input logic             busy,
   input logic             done,
   input logic             err
);
   // R4
   rst_release_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_n) |-> (!mem_clamp && !logic_clamp && done));

   // R2
   pll_needs_ldo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |-> pll_ldo_en);

   // R2
   unclamp_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(logic_clamp) |-> (sw_ok_en != '0) && (sw_on_en != '0));

   // R3
   mem_on_needs_pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_on_en |-> !mem_pd[0]);

   // R5
   ldo_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_ldo_en) |-> (!pll_en && logic_clamp && !core_rst_n && done));

   // R6
   done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   err_holds_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($stable(sw_on_en) && $stable(core_rst_n) &&
                      $stable(mem_on_en) && !busy && !done));
endmodule

bind pwr_zone_seq pzs_chk #(.LANES(LANES), .MPD_W(MPD_W)) u_pzs_chk (
   .clk(clk), .rst_n(rst_n), .pll_ldo_en(pll_ldo_en), .pll_en(pll_en),
   .sw_on_en(sw_on_en), .sw_ok_en(sw_ok_en), .logic_clamp(logic_clamp),
   .mem_pd(mem_pd), .mem_on_en(mem_on_en), .mem_clamp(mem_clamp),
   .core_rst_n(core_rst_n), .busy(busy), .done(done), .err(err));

// File: tb/pwr_zone_seq_bench.sv
module pwr_zone_seq_bench;
   localparam int DLY = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // primary instance
   logic       up_req = 0, dn_req = 0;
   logic [3:0] sw_on_sts, sw_ok_sts, sw_on_en, sw_ok_en, mem_pd;
   logic       mem_on_sts, mem_ok_sts, pll_ldo_en, pll_en, pll_clamp, logic_clamp;
   logic       mem_on_en, mem_ok_en, mem_clamp, core_rst_n, busy, done, err;
   int         fault = 0;

   pwr_zone_seq u_pwr_zone_seq (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
      .sw_on_sts(sw_on_sts), .sw_ok_sts(sw_ok_sts),
      .mem_on_sts(mem_on_sts), .mem_ok_sts(mem_ok_sts),
      .pll_ldo_en(pll_ldo_en), .pll_en(pll_en), .pll_clamp(pll_clamp),
      .sw_on_en(sw_on_en), .sw_ok_en(sw_ok_en), .logic_clamp(logic_clamp),
      .mem_pd(mem_pd), .mem_on_en(mem_on_en), .mem_ok_en(mem_ok_en),
      .mem_clamp(mem_clamp), .core_rst_n(core_rst_n),
      .busy(busy), .done(done), .err(err));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_on_sts <= '0; sw_ok_sts <= '0; mem_on_sts <= 1'b0; mem_ok_sts <= 1'b0;
      end else begin
         sw_on_sts  <= sw_on_en;
         sw_ok_sts  <= (fault == 2) ? 4'hF : sw_ok_en;
         mem_on_sts <= (fault == 1) ? 1'b0 : mem_on_en;
         mem_ok_sts <= mem_ok_en;
      end
   end

   // secondary-core instance
   logic       up_s = 0, dn_s = 0;
   logic [3:0] son_sts_s, sok_sts_s, son_en_s, sok_en_s, mpd_s;
   logic       mon_sts_s, mok_sts_s, ldo_s, pll_s, pcl_s, lcl_s;
   logic       mon_s, mok_s, mcl_s, crst_s, busy_s, done_s, err_s;

   pwr_zone_seq #(.SECONDARY(1'b1)) u_pwr_zone_seq_sec (
      .clk(clk), .rst_n(rst_n), .up_req(up_s), .dn_req(dn_s),
      .sw_on_sts(son_sts_s), .sw_ok_sts(sok_sts_s),
      .mem_on_sts(mon_sts_s), .mem_ok_sts(mok_sts_s),
      .pll_ldo_en(ldo_s), .pll_en(pll_s), .pll_clamp(pcl_s),
      .sw_on_en(son_en_s), .sw_ok_en(sok_en_s), .logic_clamp(lcl_s),
      .mem_pd(mpd_s), .mem_on_en(mon_s), .mem_ok_en(mok_s),
      .mem_clamp(mcl_s), .core_rst_n(crst_s),
      .busy(busy_s), .done(done_s), .err(err_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         son_sts_s <= '0; sok_sts_s <= '0; mon_sts_s <= 1'b0; mok_sts_s <= 1'b0;
      end else begin
         son_sts_s <= son_en_s; sok_sts_s <= sok_en_s;
         mon_sts_s <= mon_s;    mok_sts_s <= mok_s;
      end
   end

   // edge monitor
   int   cyc_all = 0;
   int   t_ldo_up = 0, t_pll_up = 0, t_pll_dn = 0, t_ldo_dn = 0;
   logic p_ldo = 0, p_pll = 0, p_rst = 0, p_lcl = 1, p_mok = 0;
   logic s_mcl = 1, s_lcl = 1, s_pcl = 1, s_done = 0, s_monsts = 0;
   logic [3:0] s_ok = 0;

   always @(negedge clk) begin
      cyc_all++;
      if (pll_ldo_en && !p_ldo) t_ldo_up = cyc_all;
      if (!pll_ldo_en && p_ldo) t_ldo_dn = cyc_all;
      if (pll_en && !p_pll)     t_pll_up = cyc_all;
      if (!pll_en && p_pll)     t_pll_dn = cyc_all;
      if (core_rst_n && !p_rst) begin
         s_mcl = mem_clamp; s_lcl = logic_clamp; s_pcl = pll_clamp; s_done = done;
      end
      if (!logic_clamp && p_lcl) s_ok = sw_ok_sts;
      if (mem_ok_en && !p_mok)   s_monsts = mem_on_sts;
      p_ldo = pll_ldo_en; p_pll = pll_en; p_rst = core_rst_n;
      p_lcl = logic_clamp; p_mok = mem_ok_en;
   end

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic up, input logic dn, output logic imm,
                         output logic busy_first, output int cyc);
      @(negedge clk); up_req = up; dn_req = dn;
      @(negedge clk); up_req = 0; dn_req = 0;
      imm = 0; cyc = 0; busy_first = busy;
      while (cyc < 3000) begin
         if (done) begin imm = (cyc == 0); break; end
         if (!busy && err) break;
         @(negedge clk); cyc++;
      end
      if (cyc >= 3000) chk("R10 sequence end", 32'd0, 32'd1);
   endtask

   // [14:13] op (1 up, 2 down), [12:11] fault, [10] imm, [9] err, [8] rst_n,
   // [7] logic_clamp, [6] mem_clamp, [5] mem_on_en, [4:1] sw_on_en, [0] pll_en
   localparam logic [14:0] VEC [10] = '{
      15'b01_00_0_0_1_0_0_1_1111_1,
      15'b01_00_1_0_1_0_0_1_1111_1,
      15'b10_00_0_0_0_1_1_0_0000_0,
      15'b10_00_1_0_0_1_1_0_0000_0,
      15'b01_01_0_1_0_0_1_1_1111_1,
      15'b10_00_0_0_0_1_1_0_0000_0,
      15'b01_00_0_0_1_0_0_1_1111_1,
      15'b10_10_0_1_0_1_1_0_1111_1,
      15'b01_00_0_0_1_0_0_1_1111_1,
      15'b10_00_0_0_0_1_1_0_0000_0
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic imm, bf;
      int   cyc;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pll_ldo_en", pll_ldo_en, 0); chk("R1 pll_en", pll_en, 0);
      chk("R1 pll_clamp", pll_clamp, 1);   chk("R1 sw_on_en", sw_on_en, 0);
      chk("R1 sw_ok_en", sw_ok_en, 0);     chk("R1 logic_clamp", logic_clamp, 1);
      chk("R1 mem_pd", mem_pd, 4'hF);      chk("R1 mem_on_en", mem_on_en, 0);
      chk("R1 mem_ok_en", mem_ok_en, 0);   chk("R1 mem_clamp", mem_clamp, 1);
      chk("R1 core_rst_n", core_rst_n, 0); chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);             chk("R1 err", err, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 10; i++) begin
         logic [14:0] v;
         v = VEC[i];
         fault = int'(v[12:11]);
         run_op(v[14:13] == 2'd1, v[14:13] == 2'd2, imm, bf, cyc);
         chk("R6 immediate done", imm, v[10]);
         if (!v[10]) chk("R10 busy after accept", bf, 1);
         chk("R7 err", err, v[9]);
         chk("R4 core_rst_n", core_rst_n, v[8]);
         chk("R2 logic_clamp", logic_clamp, v[7]);
         chk("R3 mem_clamp", mem_clamp, v[6]);
         chk("R3 mem_on_en", mem_on_en, v[5]);
         chk("R3 mem_pd", mem_pd, v[5] ? 4'hE : 4'hF);
         chk("R2 sw_on_en", sw_on_en, v[4:1]);
         chk("R5 pll_en", pll_en, v[0]);
         @(negedge clk);
         chk("R7 outputs held after stop", {core_rst_n, mem_on_en, sw_on_en}, {v[8], v[5], v[4:1]});
         fault = 0;
      end

      // R5 regulator drops only after the settling delay
      chk("R5 pll to ldo off gap", (t_ldo_dn - t_pll_dn) >= DLY, 1);

      // R8 down request during power-up ignored
      @(negedge clk); up_req = 1;
      @(negedge clk); up_req = 0;
      repeat (5) @(negedge clk);
      dn_req = 1; @(negedge clk); dn_req = 0;
      cyc = 0;
      while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
      @(negedge clk);
      chk("R8 busy request ignored", {core_rst_n, busy}, 2'b10);
      chk("R2 ldo to pll gap", (t_pll_up - t_ldo_up) >= DLY, 1);
      chk("R2 ok status before unclamp", s_ok, 4'hF);
      chk("R3 mem_on status before mem_ok", s_monsts, 1);
      chk("R4 clamps open at reset release", {s_mcl, s_lcl, s_pcl}, 3'b000);
      chk("R4 done with reset release", s_done, 1);

      // R8 both requests at once: up wins (zone already on -> immediate)
      run_op(1, 1, imm, bf, cyc);
      chk("R8 up priority", {imm, core_rst_n, logic_clamp}, 3'b110);

      // R9 secondary variant
      @(negedge clk); up_s = 1;
      @(negedge clk); up_s = 0;
      cyc = 0;
      while (!done_s && cyc < 3000) begin @(negedge clk); cyc++; end
      chk("R9 sec sw_on_en", son_en_s, 4'h3);
      chk("R9 sec sw_ok_en", sok_en_s, 4'h3);
      chk("R9 sec pll held off", {ldo_s, pll_s, pcl_s}, 3'b001);
      chk("R9 sec core on", {crst_s, lcl_s, mcl_s, mpd_s}, {3'b100, 4'hE});
      @(negedge clk); dn_s = 1;
      @(negedge clk); dn_s = 0;
      cyc = 0;
      while (!done_s && cyc < 3000) begin @(negedge clk); cyc++; end
      chk("R9 sec off", {son_en_s, sok_en_s, crst_s, lcl_s, err_s}, {8'h00, 3'b010});

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule